// File: doc/BRIEF.md
# Scatter-Gather Descriptor Walker

This block converts a list of memory descriptors into a stream of (address, length) segments for a downstream data mover. After a start pulse with scatter-gather enabled, it reads the list one 8-byte descriptor at a time through a single-outstanding 32-bit read port. Each descriptor becomes one segment on a valid/ready output. The walk stops after the descriptor that carries the end flag. If no end flag turns up within a fixed number of descriptors, the walk stops and reports an error.

With scatter-gather disabled, the block makes no memory reads. It emits one segment built from the direct source address and length inputs, marked as the final one. A completion pulse follows the final accepted segment. Start pulses that arrive while a walk is in progress have no effect.

Top module: `sg_desc_walker`

## Requirements
- R1: For descriptor k, counting from 0, the block issues two word read requests. The length word is read at `list_base + 8k`, then the pointer word at `list_base + 8k + 4`. Only one request is in flight at a time, and an address is held while its request waits for ready.
- R2: The segment length is bits [27:0] of the length word. Bits [30:28] of the length word never reach `seg_len`.
- R3: The segment address is the pointer word with bit 31 forced to zero.
- R4: A segment has `seg_last` high exactly when bit 31 of its length word is set. No memory read follows the fetch of that descriptor.
- R5: `done` is high for exactly one cycle. That cycle is the one after the cycle in which a segment with `seg_last` high was accepted (`seg_valid` and `seg_ready` both high).
- R6: If 256 descriptors have been emitted and none had the end flag, the block issues no more reads. `error` then pulses for one cycle, in the cycle after the 256th segment is accepted, and `done` stays low. A list whose end flag sits in descriptor 255 completes normally.
- R7: When `sg_enable` is low at start, exactly one segment is emitted, with address `src_addr`, length `src_len` and `seg_last` high. It appears in the cycle after start, no memory read is made, and `done` follows as in R5.
- R8: A start pulse received while a walk is in progress is ignored. The segment sequence and the read addresses of the running walk are unchanged.
- R9: While `seg_valid` is high and `seg_ready` is low, the segment stays valid and its address, length and last flag stay unchanged.
- R10: A segment is presented only after both words of its descriptor have returned. `seg_valid` and `mem_req_valid` are never high together.
- R11: During and right after reset, `mem_req_valid`, `seg_valid`, `done` and `error` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin a walk |
| sg_enable | input | 1 | 1: walk the list; 0: emit one direct segment |
| list_base | input | 32 | Byte address of descriptor 0 |
| src_addr | input | 31 | Direct-mode segment address |
| src_len | input | 28 | Direct-mode segment length |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Read request accepted |
| mem_req_addr | output | 32 | Byte address of the requested word |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data word |
| seg_valid | output | 1 | Segment valid |
| seg_ready | input | 1 | Downstream accepts segment |
| seg_addr | output | 32 | Segment byte address |
| seg_len | output | 28 | Segment byte count |
| seg_last | output | 1 | Final segment of the walk |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | One-cycle missing-end-marker pulse |

## Verification
All checks sample on the falling edge, half a cycle after the rising edge that updates the outputs. The bench decides that a segment is accepted from the `seg_valid` and `seg_ready` values it sees just before the rising edge. It then expects `done` or `error` at the very next falling edge, one register stage later, and requires both to be low at every other falling edge. A read request is checked in the sample before the edge that accepts it; the memory model answers one cycle after acceptance. A direct-mode segment is expected in the sample that follows the start edge. Segment contents are compared in order against values the bench computes from its own descriptor formula, so a segment that arrives late but correct still passes, while any change in order, value or count fails.

// File: rtl/sgw_pkg.sv
package sgw_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_REQ_LEN,
      ST_WAIT_LEN,
      ST_REQ_PTR,
      ST_WAIT_PTR,
      ST_EMIT,
      ST_FIN_OK,
      ST_FIN_ERR
   } walk_st_e;

endpackage

// File: rtl/sgw_entry_ctr.sv
module sgw_entry_ctr #(
   parameter int AW          = 32,
   parameter int MAX_ENTRIES = 256,
   parameter int DESC_BYTES  = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [AW-1:0] base,
   input  logic          advance,
   output logic [AW-1:0] desc_addr,
   output logic          at_limit
);

   localparam int IDX_W = (MAX_ENTRIES > 1) ? $clog2(MAX_ENTRIES) : 1;
   localparam bit POW2  = (MAX_ENTRIES > 1) && ((MAX_ENTRIES & (MAX_ENTRIES - 1)) == 0);

   logic [IDX_W-1:0] idx_q;
   logic [AW-1:0]    addr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q  <= '0;
         addr_q <= '0;
      end else if (load) begin
         idx_q  <= '0;
         addr_q <= base;
      end else if (advance) begin
         idx_q  <= idx_q + 1'b1;
         addr_q <= addr_q + AW'(DESC_BYTES);
      end
   end

   assign desc_addr = addr_q;

   generate
      if (MAX_ENTRIES == 1) begin : g_single
         assign at_limit = 1'b1;
      end else if (POW2) begin : g_pow2
         assign at_limit = &idx_q;
      end else begin : g_cmp
         assign at_limit = (idx_q == IDX_W'(MAX_ENTRIES - 1));
      end
   endgenerate

endmodule

// File: rtl/sgw_seg_hold.sv
module sgw_seg_hold #(
   parameter int AW    = 32,
   parameter int LEN_W = 28
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [AW-1:0]    ld_addr,
   input  logic [LEN_W-1:0] ld_len,
   input  logic             ld_last,
   input  logic             ready,
   output logic             valid,
   output logic [AW-1:0]    addr,
   output logic [LEN_W-1:0] len,
   output logic             last,
   output logic             accept
);

   logic             valid_q;
   logic [AW-1:0]    addr_q;
   logic [LEN_W-1:0] len_q;
   logic             last_q;

   assign accept = valid_q & ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         addr_q  <= '0;
         len_q   <= '0;
         last_q  <= 1'b0;
      end else begin
         if (load) begin
            valid_q <= 1'b1;
            addr_q  <= ld_addr;
            len_q   <= ld_len;
            last_q  <= ld_last;
         end else if (accept) begin
            valid_q <= 1'b0;
         end
      end
   end

   assign valid = valid_q;
   assign addr  = addr_q;
   assign len   = len_q;
   assign last  = last_q;

endmodule

// File: rtl/sgw_walk_fsm.sv
module sgw_walk_fsm
   import sgw_pkg::*;
#(
   parameter int AW        = 32,
   parameter int DW        = 32,
   parameter int LEN_W     = 28,
   parameter int ADDR_KEEP = 31,
   parameter int END_BIT   = 31
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   input  logic                 sg_enable,
   input  logic [ADDR_KEEP-1:0] src_addr,
   input  logic [LEN_W-1:0]     src_len,
   input  logic [AW-1:0]        desc_addr,
   input  logic                 at_limit,
   output logic                 mem_req_valid,
   output logic [AW-1:0]        mem_req_addr,
   input  logic                 mem_req_ready,
   input  logic                 mem_rsp_valid,
   input  logic [DW-1:0]        mem_rsp_data,
   input  logic                 seg_accept,
   input  logic                 seg_last_q,
   output logic                 ctr_load,
   output logic                 ctr_adv,
   output logic                 seg_load,
   output logic [AW-1:0]        ld_addr,
   output logic [LEN_W-1:0]     ld_len,
   output logic                 ld_last,
   output logic                 done,
   output logic                 error
);

   localparam int WORD_BYTES = DW / 8;

   walk_st_e         st_q, st_d;
   logic [LEN_W-1:0] len_q;
   logic             end_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= ST_IDLE;
         len_q <= '0;
         end_q <= 1'b0;
      end else begin
         st_q <= st_d;
         if (st_q == ST_WAIT_LEN && mem_rsp_valid) begin
            len_q <= mem_rsp_data[LEN_W-1:0];
            end_q <= mem_rsp_data[END_BIT];
         end
      end
   end

   always_comb begin
      st_d          = st_q;
      mem_req_valid = 1'b0;
      mem_req_addr  = '0;
      ctr_load      = 1'b0;
      ctr_adv       = 1'b0;
      seg_load      = 1'b0;
      ld_addr       = '0;
      ld_len        = '0;
      ld_last       = 1'b0;
      case (st_q)
         ST_IDLE: begin
            if (start) begin
               ctr_load = 1'b1;
               if (sg_enable) begin
                  st_d = ST_REQ_LEN;
               end else begin
                  seg_load = 1'b1;
                  ld_addr  = AW'(src_addr);
                  ld_len   = src_len;
                  ld_last  = 1'b1;
                  st_d     = ST_EMIT;
               end
            end
         end
         ST_REQ_LEN: begin
            mem_req_valid = 1'b1;
            mem_req_addr  = desc_addr;
            if (mem_req_ready) st_d = ST_WAIT_LEN;
         end
         ST_WAIT_LEN: begin
            if (mem_rsp_valid) st_d = ST_REQ_PTR;
         end
         ST_REQ_PTR: begin
            mem_req_valid = 1'b1;
            mem_req_addr  = desc_addr + AW'(WORD_BYTES);
            if (mem_req_ready) st_d = ST_WAIT_PTR;
         end
         ST_WAIT_PTR: begin
            if (mem_rsp_valid) begin
               seg_load = 1'b1;
               ld_addr  = AW'(mem_rsp_data[ADDR_KEEP-1:0]);
               ld_len   = len_q;
               ld_last  = end_q;
               st_d     = ST_EMIT;
            end
         end
         ST_EMIT: begin
            if (seg_accept) begin
               if (seg_last_q) begin
                  st_d = ST_FIN_OK;
               end else if (at_limit) begin
                  st_d = ST_FIN_ERR;
               end else begin
                  ctr_adv = 1'b1;
                  st_d    = ST_REQ_LEN;
               end
            end
         end
         ST_FIN_OK:  st_d = ST_IDLE;
         ST_FIN_ERR: st_d = ST_IDLE;
         default:    st_d = ST_IDLE;
      endcase
   end

   assign done  = (st_q == ST_FIN_OK);
   assign error = (st_q == ST_FIN_ERR);

endmodule

// File: rtl/sg_desc_walker.sv
module sg_desc_walker #(
   parameter int AW          = 32,
   parameter int DW          = 32,
   parameter int LEN_W       = 28,
   parameter int ADDR_KEEP   = 31,
   parameter int END_BIT     = 31,
   parameter int MAX_ENTRIES = 256,
   parameter int DESC_BYTES  = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   input  logic                 sg_enable,
   input  logic [AW-1:0]        list_base,
   input  logic [ADDR_KEEP-1:0] src_addr,
   input  logic [LEN_W-1:0]     src_len,
   output logic                 mem_req_valid,
   input  logic                 mem_req_ready,
   output logic [AW-1:0]        mem_req_addr,
   input  logic                 mem_rsp_valid,
   input  logic [DW-1:0]        mem_rsp_data,
   output logic                 seg_valid,
   input  logic                 seg_ready,
   output logic [AW-1:0]        seg_addr,
   output logic [LEN_W-1:0]     seg_len,
   output logic                 seg_last,
   output logic                 done,
   output logic                 error
);

   generate
      if (END_BIT >= DW || LEN_W > END_BIT) begin : g_bad_len
         $error("sg_desc_walker: length field must sit below the end flag inside one word");
      end
      if (ADDR_KEEP > AW || ADDR_KEEP > DW) begin : g_bad_addr
         $error("sg_desc_walker: kept address bits exceed bus width");
      end
      if (DESC_BYTES < 2 * (DW / 8) || DW % 8 != 0) begin : g_bad_desc
         $error("sg_desc_walker: descriptor must hold two whole words");
      end
      if (MAX_ENTRIES < 1) begin : g_bad_max
         $error("sg_desc_walker: entry limit must be positive");
      end
   endgenerate

   logic          ctr_load, ctr_adv, at_limit;
   logic [AW-1:0] desc_addr;
   logic          seg_load, ld_last, seg_accept;
   logic [AW-1:0] ld_addr;
   logic [LEN_W-1:0] ld_len;

   sgw_entry_ctr #(
      .AW(AW), .MAX_ENTRIES(MAX_ENTRIES), .DESC_BYTES(DESC_BYTES)
   ) u_ctr (
      .clk(clk), .rst_n(rst_n), .load(ctr_load), .base(list_base),
      .advance(ctr_adv), .desc_addr(desc_addr), .at_limit(at_limit)
   );

   sgw_walk_fsm #(
      .AW(AW), .DW(DW), .LEN_W(LEN_W), .ADDR_KEEP(ADDR_KEEP), .END_BIT(END_BIT)
   ) u_fsm (
      .clk(clk), .rst_n(rst_n), .start(start), .sg_enable(sg_enable),
      .src_addr(src_addr), .src_len(src_len),
      .desc_addr(desc_addr), .at_limit(at_limit),
      .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
      .mem_req_ready(mem_req_ready), .mem_rsp_valid(mem_rsp_valid),
      .mem_rsp_data(mem_rsp_data), .seg_accept(seg_accept), .seg_last_q(seg_last),
      .ctr_load(ctr_load), .ctr_adv(ctr_adv), .seg_load(seg_load),
      .ld_addr(ld_addr), .ld_len(ld_len), .ld_last(ld_last),
      .done(done), .error(error)
   );

   sgw_seg_hold #(
      .AW(AW), .LEN_W(LEN_W)
   ) u_seg (
      .clk(clk), .rst_n(rst_n), .load(seg_load), .ld_addr(ld_addr),
      .ld_len(ld_len), .ld_last(ld_last), .ready(seg_ready),
      .valid(seg_valid), .addr(seg_addr), .len(seg_len), .last(seg_last),
      .accept(seg_accept)
   );

endmodule

// File: rtl/sgw_walker_chk.sv
module sgw_walker_chk #(
   parameter int AW        = 32,
   parameter int LEN_W     = 28,
   parameter int ADDR_KEEP = 31
) (
   input logic             clk,
   input logic             rst_n,
   input logic             mem_req_valid,
   input logic             mem_req_ready,
   input logic [AW-1:0]    mem_req_addr,
   input logic             seg_valid,
   input logic             seg_ready,
   input logic [AW-1:0]    seg_addr,
   input logic [LEN_W-1:0] seg_len,
   input logic             seg_last,
   input logic             done,
   input logic             error
);

   assert_req_aligned_R1: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |-> (mem_req_addr[1:0] == 2'b00));

   assert_req_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

   assert_addr_masked_R3: assert property (@(posedge clk) disable iff (!rst_n)
      seg_valid |-> ((seg_addr >> ADDR_KEEP) == '0));

   assert_done_after_last_R5: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(seg_valid && seg_ready && seg_last));

   assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_error_after_open_R6: assert property (@(posedge clk) disable iff (!rst_n)
      error |-> $past(seg_valid && seg_ready && !seg_last));

   assert_done_error_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && error));

   assert_seg_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (seg_valid && !seg_ready) |=>
         (seg_valid && $stable(seg_addr) && $stable(seg_len) && $stable(seg_last)));

   assert_no_req_with_seg_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(seg_valid && mem_req_valid));

endmodule

bind sg_desc_walker sgw_walker_chk #(
   .AW(AW), .LEN_W(LEN_W), .ADDR_KEEP(ADDR_KEEP)
) u_chk (.*);

// File: tb/sg_desc_walker_tb_top.sv
module sg_desc_walker_tb_top;

   localparam logic [31:0] BASE = 32'h0000_4000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        sg_enable = 1'b0;
   logic [31:0] list_base = BASE;
   logic [30:0] src_addr = '0;
   logic [27:0] src_len = '0;
   logic        mem_req_valid;
   logic        mem_req_ready = 1'b0;
   logic [31:0] mem_req_addr;
   logic        mem_rsp_valid = 1'b0;
   logic [31:0] mem_rsp_data = '0;
   logic        seg_valid;
   logic        seg_ready = 1'b0;
   logic [31:0] seg_addr;
   logic [27:0] seg_len;
   logic        seg_last;
   logic        done;
   logic        error;

   always #5 clk = ~clk;

   sg_desc_walker dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .sg_enable(sg_enable),
      .list_base(list_base), .src_addr(src_addr), .src_len(src_len),
      .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
      .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
      .mem_rsp_data(mem_rsp_data), .seg_valid(seg_valid), .seg_ready(seg_ready),
      .seg_addr(seg_addr), .seg_len(seg_len), .seg_last(seg_last),
      .done(done), .error(error)
   );

   int n_checks = 0;
   int n_fail   = 0;

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s act=%0h exp=%0h", req, act, exp);
      end
   endtask

   // memory image and expected segments
   logic [31:0] memw [0:511];
   logic [31:0] exp_addr [0:255];
   logic [27:0] exp_len  [0:255];
   logic        exp_last [0:255];
   int          n_exp = 0;
   bit          exp_err = 1'b0;
   int          seg_k = 0;
   int          req_cnt = 0;
   int          saw_done = 0;
   int          saw_err = 0;
   bit          walk_end = 1'b0;

   function automatic logic [31:0] gen_len(input int s, input int i, input bit endf);
      logic [31:0] v;
      v = 32'(s * 977 + i * 1031 + 1) & 32'h0FFF_FFFF;
      v = v | (32'((s + i * 5) & 7) << 28);
      if (endf) v = v | 32'h8000_0000;
      return v;
   endfunction

   function automatic logic [31:0] gen_ptr(input int s, input int i);
      logic [31:0] v;
      v = (32'(s) << 20) ^ 32'(i * 32'h1357);
      if ((i & 1) != 0) v = v | 32'h8000_0000;
      return v;
   endfunction

   // memory model: one-cycle read latency
   int mrdy_ctr = 0;
   always @(posedge clk) begin
      mrdy_ctr <= mrdy_ctr + 1;
      mem_req_ready <= ((mrdy_ctr % 4) != 3);
      mem_rsp_valid <= 1'b0;
      if (rst_n && mem_req_valid && mem_req_ready) begin
         mem_rsp_valid <= 1'b1;
         mem_rsp_data  <= memw[((mem_req_addr - BASE) >> 2) & 32'h1FF];
      end
   end

   // output monitor and downstream ready pattern
   int          srdy_ctr = 0;
   bit          pend_done = 1'b0;
   bit          pend_err = 1'b0;
   bit          hold_pend = 1'b0;
   logic [31:0] h_addr;
   logic [27:0] h_len;
   logic        h_last;

   always @(negedge clk) begin
      if (rst_n) begin
         if (pend_done) chk(done === 1'b1, "R5 done pulse after last accept", 64'(done), 64'd1);
         else if (done) chk(1'b0, "R5 done without final accept", 64'(done), 64'd0);
         if (pend_err) chk(error === 1'b1, "R6 error pulse after entry limit", 64'(error), 64'd1);
         else if (error) chk(1'b0, "R6 unexpected error", 64'(error), 64'd0);
         if (done) begin saw_done++; walk_end = 1'b1; end
         if (error) begin saw_err++; walk_end = 1'b1; end
         pend_done = 1'b0;
         pend_err  = 1'b0;

         if (hold_pend)
            chk(seg_valid && seg_addr == h_addr && seg_len == h_len && seg_last == h_last,
                "R9 segment held while stalled", {31'd0, seg_valid, seg_addr}, {31'd1, h_addr});

         if (mem_req_valid && mem_req_ready) begin
            chk(mem_req_addr == BASE + 32'(4 * req_cnt), "R1 read address order",
                64'(mem_req_addr), 64'(BASE + 32'(4 * req_cnt)));
            req_cnt++;
         end

         srdy_ctr++;
         seg_ready = ((srdy_ctr % 3) != 0);
         hold_pend = seg_valid && !seg_ready;
         h_addr = seg_addr;
         h_len  = seg_len;
         h_last = seg_last;

         if (seg_valid && seg_ready) begin
            if (seg_k < n_exp) begin
               chk(seg_len == exp_len[seg_k], "R2 segment length", 64'(seg_len), 64'(exp_len[seg_k]));
               chk(seg_addr == exp_addr[seg_k], "R3 segment address", 64'(seg_addr), 64'(exp_addr[seg_k]));
               chk(seg_last == exp_last[seg_k], "R4 last flag", 64'(seg_last), 64'(exp_last[seg_k]));
               if (exp_last[seg_k]) pend_done = 1'b1;
               if (exp_err && seg_k == n_exp - 1) pend_err = 1'b1;
            end else begin
               chk(1'b0, "R4 segment after end of walk", 64'(seg_k), 64'(n_exp));
            end
            seg_k++;
         end
      end
   end

   task automatic pulse_start(input bit sg, input logic [31:0] base);
      @(negedge clk);
      sg_enable = sg;
      list_base = base;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic clear_walk();
      seg_k = 0; req_cnt = 0; saw_done = 0; saw_err = 0; walk_end = 1'b0;
   endtask

   task automatic run_sg(input int s, input int n, input bit has_end, input bit poke);
      for (int i = 0; i < n; i++) begin
         bit e;
         e = has_end && (i == n - 1);
         memw[2 * i]     = gen_len(s, i, e);
         memw[2 * i + 1] = gen_ptr(s, i);
         exp_len[i]  = memw[2 * i][27:0];
         exp_addr[i] = memw[2 * i + 1] & 32'h7FFF_FFFF;
         exp_last[i] = e;
      end
      n_exp = n;
      exp_err = !has_end;
      clear_walk();
      pulse_start(1'b1, BASE);
      if (poke) begin
         repeat (6) @(negedge clk);
         sg_enable = 1'b0;
         list_base = BASE + 32'h100;
         start = 1'b1;
         @(negedge clk);
         start = 1'b0;
         list_base = BASE;
      end
      while (!walk_end) @(negedge clk);
      repeat (4) @(negedge clk);
      chk(seg_k == n, poke ? "R8 segment count with stray start" : "R4 segment count",
          64'(seg_k), 64'(n));
      chk(req_cnt == 2 * n, has_end ? "R4 no reads after end" : "R6 no reads after limit",
          64'(req_cnt), 64'(2 * n));
      chk(saw_done == (has_end ? 1 : 0), "R5 done count", 64'(saw_done), 64'(has_end ? 1 : 0));
      chk(saw_err == (has_end ? 0 : 1), "R6 error count", 64'(saw_err), 64'(has_end ? 0 : 1));
      chk(!seg_valid && !mem_req_valid, "R8 idle after walk", {62'd0, seg_valid, mem_req_valid}, 64'd0);
   endtask

   task automatic run_direct(input logic [30:0] a, input logic [27:0] l);
      exp_addr[0] = {1'b0, a};
      exp_len[0]  = l;
      exp_last[0] = 1'b1;
      n_exp = 1;
      exp_err = 1'b0;
      clear_walk();
      src_addr = a;
      src_len  = l;
      @(negedge clk);
      sg_enable = 1'b0;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(seg_valid && seg_last, "R7 direct segment one cycle after start",
          {62'd0, seg_valid, seg_last}, 64'd3);
      while (!walk_end) @(negedge clk);
      repeat (3) @(negedge clk);
      chk(req_cnt == 0, "R7 no memory reads in direct mode", 64'(req_cnt), 64'd0);
      chk(seg_k == 1, "R7 single direct segment", 64'(seg_k), 64'd1);
      chk(saw_done == 1, "R7 done after direct segment", 64'(saw_done), 64'd1);
   endtask

   initial begin
      repeat (5) @(negedge clk);
      chk(!mem_req_valid && !seg_valid && !done && !error, "R11 outputs low in reset",
          {60'd0, mem_req_valid, seg_valid, done, error}, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!mem_req_valid && !seg_valid && !done && !error, "R11 outputs low after reset",
          {60'd0, mem_req_valid, seg_valid, done, error}, 64'd0);

      for (int n = 1; n <= 9; n++) run_sg(n, n, 1'b1, 1'b0);
      run_sg(20, 5, 1'b1, 1'b1);
      run_direct(31'h7FFF_FFFF, 28'hFFF_FFFF);
      run_direct(31'h0000_0000, 28'h000_0000);
      run_direct(31'h1234_5678, 28'hABC_DEF1);
      run_sg(30, 256, 1'b1, 1'b0);
      run_sg(31, 256, 1'b0, 1'b0);
      run_sg(32, 3, 1'b1, 1'b0);

      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL R4 watchdog act=walk_not_finished exp=walk_finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end

endmodule